// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two normalized binary floating-point numbers in four clocked segments. Each number has a sign bit, a two's-complement exponent and a magnitude mantissa. The mantissa is a pure fraction: the binary point sits left of its top bit, so a normalized value has that top bit set and lies in [1/2, 1). The value is (-1)^sign × mantissa × 2^exponent.

The segments run in a fixed order. The first compares the exponents by subtraction. The second shifts the smaller-exponent mantissa right to line it up with the other one. The third adds or subtracts the two magnitudes. The fourth renormalizes the result. A new operand pair may enter on every clock, marked by a valid flag, and its result leaves four clocks later with the flag set.

There is no rounding. Bits shifted out during alignment are dropped. Special values and exception flags are not handled, and exponents that go past the format's range wrap around.

Top module: `fpadd_pipe4`

## Requirements
- R1: A pair sampled with `in_valid`=1 at a rising edge produces `out_valid`=1 and its result after exactly four rising edges. An edge that samples `in_valid`=0 produces `out_valid`=0 four edges later. Back-to-back pairs give back-to-back results.
- R2: A valid nonzero result has mantissa bit 15 set. Bit 15 has weight 1/2 and bit 0 has weight 2^-16.
- R3: A result whose magnitude is zero is output as sign 0, exponent 0 and mantissa 0. This covers x−x and x+(−x).
- R4: The result starts from the larger of the two exponents, which are 8-bit two's-complement values. The other mantissa is shifted right by the exponent difference, and the bits shifted out are discarded. A difference of 16 or more aligns that mantissa to zero.
- R5: When the magnitude sum reaches 1.0 or more, the result mantissa is that sum shifted right by one and the exponent is incremented by one.
- R6: When the magnitude result is nonzero but has bit 15 clear, the mantissa is shifted left until bit 15 is set. The exponent is decreased by one for each position shifted.
- R7: With `sub_op`=1 the block computes a − b, which is the same as flipping b's sign. When the effective signs differ, the smaller aligned magnitude is subtracted from the larger one, and the result takes the sign of the larger one. A subtraction never produces a carry out.
- R8: While `rst_n` is low and after its release, `out_valid`, `z_sign`, `z_exp` and `z_man` read 0 until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| sub_op | input | 1 | 1 = a − b, 0 = a + b |
| a_sign | input | 1 | Sign of a (1 = negative) |
| a_exp | input | 8 | Exponent of a, two's complement |
| a_man | input | 16 | Fractional mantissa magnitude of a |
| b_sign | input | 1 | Sign of b |
| b_exp | input | 8 | Exponent of b, two's complement |
| b_man | input | 16 | Fractional mantissa magnitude of b |
| out_valid | output | 1 | Result present this cycle |
| z_sign | output | 1 | Sign of result |
| z_exp | output | 8 | Exponent of result |
| z_man | output | 16 | Normalized mantissa of result |

## Verification
The embedded assertions check the following on every cycle:
- the four-edge valid latency;
- that every valid result is either normalized or the canonical zero;
- that a nonzero alignment shift always clears the aligned mantissa's top bit, and that a shift of 16 or more clears it entirely;
- that a subtraction never carries;
- that a carried sum is shifted right with the exponent bumped by one.

Only the bench's scenarios can show the arithmetic values. These include the exponent chosen, the bits dropped during alignment, the sign picked when b outweighs a, the length of the left shift after cancellation, and exact zero results. The bench checks them by comparing every cycle against a behavioural model running on integers.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   localparam int unsigned FPA_EXP_W_DEF = 8;
   localparam int unsigned FPA_MAN_W_DEF = 16;

   // normalization action chosen in the last segment
   typedef enum logic [1:0] {
      NRM_PASS,
      NRM_RIGHT,
      NRM_LEFT,
      NRM_ZERO
   } nrm_kind_e;
endpackage

// File: rtl/fpa_cmp_stage.sv
// Segment 1: exponent compare by subtraction, operand ordering.
module fpa_cmp_stage #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 16,
   localparam int SH_W = $clog2(MAN_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic             sub_i,
   input  logic             as_i,
   input  logic [EXP_W-1:0] ae_i,
   input  logic [MAN_W-1:0] am_i,
   input  logic             bs_i,
   input  logic [EXP_W-1:0] be_i,
   input  logic [MAN_W-1:0] bm_i,
   output logic             v_o,
   output logic             bgs_o,
   output logic [MAN_W-1:0] bgm_o,
   output logic             sms_o,
   output logic [MAN_W-1:0] smm_o,
   output logic [SH_W-1:0]  sh_o,
   output logic [EXP_W-1:0] e_o
);
   logic signed [EXP_W:0] dif;
   logic [EXP_W:0]        mag;
   logic                  a_big;
   logic                  bs_eff;
   logic [SH_W-1:0]       sh_c;

   assign dif    = $signed({ae_i[EXP_W-1], ae_i}) - $signed({be_i[EXP_W-1], be_i});
   assign a_big  = ~dif[EXP_W];
   assign mag    = a_big ? $unsigned(dif) : $unsigned(-dif);
   assign bs_eff = bs_i ^ sub_i;
   assign sh_c   = (mag >= (EXP_W+1)'(MAN_W)) ? SH_W'(MAN_W) : SH_W'(mag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         bgs_o <= 1'b0;
         bgm_o <= '0;
         sms_o <= 1'b0;
         smm_o <= '0;
         sh_o  <= '0;
         e_o   <= '0;
      end else begin
         v_o   <= v_i;
         bgs_o <= a_big ? as_i : bs_eff;
         bgm_o <= a_big ? am_i : bm_i;
         sms_o <= a_big ? bs_eff : as_i;
         smm_o <= a_big ? bm_i : am_i;
         sh_o  <= sh_c;
         e_o   <= a_big ? ae_i : be_i;
      end
   end

   // R4: the registered shift never exceeds the mantissa width
   p_shift_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> (sh_o <= SH_W'(MAN_W)));
endmodule

// File: rtl/fpa_align_stage.sv
// Segment 2: right-shift the smaller-exponent mantissa.
module fpa_align_stage #(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 16,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int SH_W     = $clog2(MAN_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic             bgs_i,
   input  logic [MAN_W-1:0] bgm_i,
   input  logic             sms_i,
   input  logic [MAN_W-1:0] smm_i,
   input  logic [SH_W-1:0]  sh_i,
   input  logic [EXP_W-1:0] e_i,
   output logic             v_o,
   output logic             bgs_o,
   output logic [MAN_W-1:0] bgm_o,
   output logic             sms_o,
   output logic [MAN_W-1:0] al_o,
   output logic [EXP_W-1:0] e_o
);
   logic [MAN_W-1:0] shifted;

   generate
      if (LOG_SHIFT) begin : g_log
         logic [MAN_W-1:0] lvl [SH_W+1];
         assign lvl[0] = smm_i;
         for (genvar i = 0; i < SH_W; i++) begin : g_lvl
            assign lvl[i+1] = sh_i[i] ? (lvl[i] >> (2**i)) : lvl[i];
         end
         assign shifted = lvl[SH_W];
      end else begin : g_flat
         assign shifted = (sh_i >= SH_W'(MAN_W)) ? '0 : (smm_i >> sh_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         bgs_o <= 1'b0;
         bgm_o <= '0;
         sms_o <= 1'b0;
         al_o  <= '0;
         e_o   <= '0;
      end else begin
         v_o   <= v_i;
         bgs_o <= bgs_i;
         bgm_o <= bgm_i;
         sms_o <= sms_i;
         al_o  <= shifted;
         e_o   <= e_i;
      end
   end

   // R4: any nonzero shift clears the top bit; a full-width shift clears all
   p_align_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && sh_i != '0) |=> !al_o[MAN_W-1]);
   p_align_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && sh_i >= SH_W'(MAN_W)) |=> (al_o == '0));
endmodule

// File: rtl/fpa_addsub_stage.sv
// Segment 3: sign-magnitude add or subtract of aligned mantissas.
module fpa_addsub_stage #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic             bgs_i,
   input  logic [MAN_W-1:0] bgm_i,
   input  logic             sms_i,
   input  logic [MAN_W-1:0] al_i,
   input  logic [EXP_W-1:0] e_i,
   output logic             v_o,
   output logic             s_o,
   output logic [MAN_W:0]   sum_o,
   output logic [EXP_W-1:0] e_o
);
   logic [MAN_W:0] res_c;
   logic           sg_c;

   always_comb begin
      if (bgs_i == sms_i) begin
         res_c = {1'b0, bgm_i} + {1'b0, al_i};
         sg_c  = bgs_i;
      end else if (bgm_i >= al_i) begin
         res_c = {1'b0, bgm_i} - {1'b0, al_i};
         sg_c  = bgs_i;
      end else begin
         res_c = {1'b0, al_i} - {1'b0, bgm_i};
         sg_c  = sms_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         s_o   <= 1'b0;
         sum_o <= '0;
         e_o   <= '0;
      end else begin
         v_o   <= v_i;
         s_o   <= sg_c;
         sum_o <= res_c;
         e_o   <= e_i;
      end
   end

   // R7: a magnitude subtraction never carries out
   p_no_carry_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && bgs_i != sms_i) |=> !sum_o[MAN_W]);
endmodule

// File: rtl/fpa_norm_stage.sv
// Segment 4: renormalize to the 0.1xxx form or force canonical zero.
module fpa_norm_stage
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 16,
   localparam int LZ_W = $clog2(MAN_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic             s_i,
   input  logic [MAN_W:0]   sum_i,
   input  logic [EXP_W-1:0] e_i,
   output logic             v_o,
   output logic             s_o,
   output logic [EXP_W-1:0] e_o,
   output logic [MAN_W-1:0] m_o
);
   logic [LZ_W-1:0]  lz;
   logic             hit;
   nrm_kind_e        kind;
   logic             s_n;
   logic [EXP_W-1:0] e_n;
   logic [MAN_W-1:0] m_n;

   always_comb begin
      lz  = '0;
      hit = 1'b0;
      for (int i = 0; i < MAN_W; i++) begin
         if (!hit && sum_i[MAN_W-1-i]) begin
            lz  = LZ_W'(i);
            hit = 1'b1;
         end
      end
   end

   always_comb begin
      if (sum_i[MAN_W])   kind = NRM_RIGHT;
      else if (!hit)      kind = NRM_ZERO;
      else if (lz != '0)  kind = NRM_LEFT;
      else                kind = NRM_PASS;
   end

   always_comb begin
      s_n = s_i;
      e_n = e_i;
      m_n = sum_i[MAN_W-1:0];
      case (kind)
         NRM_RIGHT: begin
            m_n = sum_i[MAN_W:1];
            e_n = e_i + EXP_W'(1);
         end
         NRM_LEFT: begin
            m_n = sum_i[MAN_W-1:0] << lz;
            e_n = e_i - {{(EXP_W-LZ_W){1'b0}}, lz};
         end
         NRM_ZERO: begin
            s_n = 1'b0;
            e_n = '0;
            m_n = '0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_o <= 1'b0;
         s_o <= 1'b0;
         e_o <= '0;
         m_o <= '0;
      end else begin
         v_o <= v_i;
         s_o <= s_n;
         e_o <= e_n;
         m_o <= m_n;
      end
   end

   // R2: valid output is normalized unless it is zero
   p_normalized_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && m_o != '0) |-> m_o[MAN_W-1]);
   // R3: zero mantissa always comes with zero exponent and positive sign
   p_zero_canon_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (v_o && m_o == '0) |-> (e_o == '0 && !s_o));
   // R5: a carried sum is shifted right and the exponent bumped
   p_carry_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (v_i && sum_i[MAN_W]) |=>
         (m_o == $past(sum_i[MAN_W:1]) && e_o == $past(e_i) + EXP_W'(1)));
endmodule

// File: rtl/fpadd_pipe4.sv
module fpadd_pipe4 #(
   parameter int EXP_W     = fpa_pkg::FPA_EXP_W_DEF,
   parameter int MAN_W     = fpa_pkg::FPA_MAN_W_DEF,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             sub_op,
   input  logic             a_sign,
   input  logic [EXP_W-1:0] a_exp,
   input  logic [MAN_W-1:0] a_man,
   input  logic             b_sign,
   input  logic [EXP_W-1:0] b_exp,
   input  logic [MAN_W-1:0] b_man,
   output logic             out_valid,
   output logic             z_sign,
   output logic [EXP_W-1:0] z_exp,
   output logic [MAN_W-1:0] z_man
);
   localparam int SH_W = $clog2(MAN_W + 1);

   generate
      if (MAN_W < 4) begin : g_bad_man
         $error("fpadd_pipe4: MAN_W must be at least 4");
      end
      if (EXP_W < 3 || EXP_W <= $clog2(MAN_W)) begin : g_bad_exp
         $error("fpadd_pipe4: EXP_W too small for MAN_W");
      end
      if (MAN_W >= 2**EXP_W) begin : g_bad_ratio
         $error("fpadd_pipe4: MAN_W must be below 2**EXP_W");
      end
   endgenerate

   logic             c_v, c_bgs, c_sms;
   logic [MAN_W-1:0] c_bgm, c_smm;
   logic [SH_W-1:0]  c_sh;
   logic [EXP_W-1:0] c_e;

   logic             l_v, l_bgs, l_sms;
   logic [MAN_W-1:0] l_bgm, l_al;
   logic [EXP_W-1:0] l_e;

   logic             d_v, d_s;
   logic [MAN_W:0]   d_sum;
   logic [EXP_W-1:0] d_e;

   fpa_cmp_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .v_i(in_valid), .sub_i(sub_op),
      .as_i(a_sign), .ae_i(a_exp), .am_i(a_man),
      .bs_i(b_sign), .be_i(b_exp), .bm_i(b_man),
      .v_o(c_v), .bgs_o(c_bgs), .bgm_o(c_bgm), .sms_o(c_sms), .smm_o(c_smm),
      .sh_o(c_sh), .e_o(c_e)
   );

   fpa_align_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LOG_SHIFT(LOG_SHIFT)) u_align (
      .clk(clk), .rst_n(rst_n), .v_i(c_v), .bgs_i(c_bgs), .bgm_i(c_bgm),
      .sms_i(c_sms), .smm_i(c_smm), .sh_i(c_sh), .e_i(c_e),
      .v_o(l_v), .bgs_o(l_bgs), .bgm_o(l_bgm), .sms_o(l_sms), .al_o(l_al), .e_o(l_e)
   );

   fpa_addsub_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addsub (
      .clk(clk), .rst_n(rst_n), .v_i(l_v), .bgs_i(l_bgs), .bgm_i(l_bgm),
      .sms_i(l_sms), .al_i(l_al), .e_i(l_e),
      .v_o(d_v), .s_o(d_s), .sum_o(d_sum), .e_o(d_e)
   );

   fpa_norm_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
      .clk(clk), .rst_n(rst_n), .v_i(d_v), .s_i(d_s), .sum_i(d_sum), .e_i(d_e),
      .v_o(out_valid), .s_o(z_sign), .e_o(z_exp), .m_o(z_man)
   );

   // R1: fixed four-edge latency of the valid flag
   p_latency_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##4 out_valid);
   p_latency_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##4 !out_valid);
endmodule

// File: tb/fpadd_pipe4_tb_top.sv
module fpadd_pipe4_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, sub_op = 1'b0;
   logic        a_sign = 1'b0, b_sign = 1'b0;
   logic [7:0]  a_exp = '0, b_exp = '0;
   logic [15:0] a_man = '0, b_man = '0;
   logic        out_valid, z_sign;
   logic [7:0]  z_exp;
   logic [15:0] z_man;

   int checks = 0;
   int fails  = 0;

   logic        ev_q [4];
   logic [24:0] ed_q [4];
   string       tg_q [4];

   always #10 clk = ~clk;

   fpadd_pipe4 dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
      .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
      .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
      .out_valid(out_valid), .z_sign(z_sign), .z_exp(z_exp), .z_man(z_man)
   );

   // behavioural reference on integers: returns {sign, exp[7:0], man[15:0]}
   function automatic logic [24:0] ref_add(input logic as, input logic [7:0] ae,
         input logic [15:0] am, input logic bs, input logic [7:0] be,
         input logic [15:0] bm, input logic sub);
      int ea, eb, el, es, ml, ms, d, sm, s, e;
      logic sl, ss, sg, bx;
      ea = int'($signed(ae));
      eb = int'($signed(be));
      bx = bs ^ sub;
      if (ea >= eb) begin
         el = ea; ml = int'(am); sl = as; es = eb; ms = int'(bm); ss = bx;
      end else begin
         el = eb; ml = int'(bm); sl = bx; es = ea; ms = int'(am); ss = as;
      end
      d  = el - es;
      sm = (d >= 16) ? 0 : (ms >> d);
      if (sl == ss) begin
         s = ml + sm; sg = sl;
      end else if (ml >= sm) begin
         s = ml - sm; sg = sl;
      end else begin
         s = sm - ml; sg = ss;
      end
      if (s == 0) return 25'd0;
      e = el;
      if (s >= 65536) begin
         s = s >> 1; e = e + 1;
      end
      while (s < 32768) begin
         s = s << 1; e = e - 1;
      end
      return {sg, e[7:0], s[15:0]};
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic compare_out();
      checks++;
      if (out_valid !== ev_q[3]) begin
         fails++;
         $display("FAIL %s out_valid actual=%0b expected=%0b", tg_q[3], out_valid, ev_q[3]);
      end
      if (ev_q[3]) begin
         checks++;
         if ({z_sign, z_exp, z_man} !== ed_q[3]) begin
            fails++;
            $display("FAIL %s result actual=%0b/%h/%h expected=%0b/%h/%h", tg_q[3],
                     z_sign, z_exp, z_man, ed_q[3][24], ed_q[3][23:16], ed_q[3][15:0]);
         end
      end
   endtask

   task automatic step(input string tag, input logic v, input logic sub,
         input logic as, input int ae, input logic [15:0] am,
         input logic bs, input int be, input logic [15:0] bm);
      @(negedge clk);
      compare_out();
      for (int k = 3; k > 0; k--) begin
         ev_q[k] = ev_q[k-1];
         ed_q[k] = ed_q[k-1];
         tg_q[k] = tg_q[k-1];
      end
      ev_q[0] = v;
      ed_q[0] = ref_add(as, 8'(ae), am, bs, 8'(be), bm, sub);
      tg_q[0] = tag;
      in_valid = v; sub_op = sub;
      a_sign = as; a_exp = 8'(ae); a_man = am;
      b_sign = bs; b_exp = 8'(be); b_man = bm;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step("R1", 1'b0, 1'b0, 1'b0, 0, 16'h0, 1'b0, 0, 16'h0);
   endtask

   task automatic check_reset(input string when);
      checks++;
      if ({out_valid, z_sign, z_exp, z_man} !== 26'd0) begin
         fails++;
         $display("FAIL R8 %s outputs actual=%0b/%0b/%h/%h expected=0/0/00/0000",
                  when, out_valid, z_sign, z_exp, z_man);
      end
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin
         ev_q[k] = 1'b0; ed_q[k] = '0; tg_q[k] = "R1";
      end
      repeat (3) @(negedge clk);
      check_reset("during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset("after release");

      // R4: exponent 3 vs 2, alignment by one
      step("R4", 1, 0, 0, 3, 16'hC000, 0, 2, 16'hA000);
      // R4: negative exponents, b larger
      step("R4", 1, 0, 0, -7, 16'h9000, 0, -3, 16'hF00F);
      // R4: differences 15, 16, 17 (16 and 17 align to zero)
      step("R4", 1, 0, 0, 20, 16'h8001, 0, 5, 16'hFFFF);
      step("R4", 1, 0, 0, 20, 16'h8001, 0, 4, 16'hFFFF);
      step("R4", 1, 0, 1, -10, 16'hFFFF, 0, 7, 16'hA5A5);
      // R5: carry out, same exponent
      step("R5", 1, 0, 0, 6, 16'hC000, 0, 6, 16'hC000);
      step("R5", 1, 0, 1, -2, 16'hFFFF, 1, -2, 16'hFFFF);
      // R6: cancellation with long left shift
      step("R6", 1, 1, 0, 5, 16'h8001, 0, 5, 16'h8000);
      step("R6", 1, 0, 0, 0, 16'h8000, 1, -1, 16'hFFFF);
      // R3: exact zeros
      step("R3", 1, 1, 1, 9, 16'hBEEF, 1, 9, 16'hBEEF);
      step("R3", 1, 0, 0, -4, 16'h9999, 1, -4, 16'h9999);
      // R7: subtract with larger b, mixed signs
      step("R7", 1, 1, 0, 2, 16'h8000, 0, 4, 16'hC000);
      step("R7", 1, 1, 1, 3, 16'hF000, 1, 3, 16'h8000);
      step("R7", 1, 0, 1, 1, 16'h8000, 0, 1, 16'hE000);
      // R1: bubbles between results
      idle(2);
      step("R1", 1, 0, 0, 1, 16'h8000, 0, 1, 16'h8000);
      idle(1);
      step("R1", 1, 1, 0, 1, 16'hC000, 0, 0, 16'h8000);
      idle(5);

      // R2: mixed stream
      for (int n = 0; n < 400; n++) begin
         logic v;
         v = (n % 5) != 3;
         step("R2", v, 1'($urandom), 1'($urandom), int'($urandom % 81) - 40,
              16'h8000 | 16'($urandom), 1'($urandom), int'($urandom % 81) - 40,
              16'h8000 | 16'($urandom));
      end
      idle(6);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule